// File: doc/BRIEF.md
# Two-Layer Alpha Blend Compositor

This block builds the final colour of each raster pixel from two layers. One layer is a translucent sprite with a top-left corner that can move, a fixed footprint and a per-pixel colour. The colour arrives with a valid flag, so that transparent texels of an image can drop out. The other layer is an opaque rectangle of fixed colour, pure red by default. Both layers are tested against the current raster position every pixel clock.

Where both layers cover a pixel, the red, green and blue channels are each mixed on their own with a fixed weight M/N, where N is a power of two. The sprite is weighted by M/N and the rectangle by (N-M)/N. The sum is divided by a right shift, never by a divider. Where only one layer covers a pixel, that layer's colour passes unchanged. Where neither covers it, the output is black.

The result is registered once. The horizontal sync, vertical sync and blank signals pass through a matching one-cycle delay, so they stay aligned with the colour they frame.

Top module: `alpha_compositor`

## Requirements
- R1: While reset is high, and on the first cycle after it, the colour output is 0, both sync outputs are 1 (inactive, because the syncs are active-low) and the blank output is 1.
- R2: hsync_o, vsync_o and blank_o equal hsync, vsync and blank from exactly one clock earlier.
- R3: If the sprite alone covers the position sampled at a clock edge, the colour output after that edge equals the sprite_rgb sampled at that edge.
- R4: If the rectangle alone covers the sampled position, the output after the edge is the rectangle colour, 24'hFF0000 by default.
- R5: If neither layer covers the sampled position, the output after the edge is 24'h000000.
- R6: If both layers cover the sampled position, each 8-bit channel of the output is computed as (sprite_channel*M + rect_channel*(N-M)) >> log2(N), limited to 255. R is bits 23:16, G is bits 15:8 and B is bits 7:0. The defaults are M=3 and N=4. When the two colours are equal, the output is that colour.
- R7: The sprite covers a position when sprite_vld is 1 and sprite_x <= hcount < sprite_x+64 and sprite_y <= vcount < sprite_y+64. When sprite_vld is 0, the sprite does not cover the position.
- R8: The rectangle covers a position when rect_x <= hcount < rect_x+128 and rect_y <= vcount < rect_y+128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hcount | input | 11 | Current pixel column |
| vcount | input | 10 | Current scan line |
| sprite_x | input | 11 | Sprite left column |
| sprite_y | input | 10 | Sprite top line |
| rect_x | input | 11 | Rectangle left column |
| rect_y | input | 10 | Rectangle top line |
| sprite_rgb | input | 24 | Sprite colour {R,G,B} for this position |
| sprite_vld | input | 1 | Sprite colour is opaque enough to count |
| hsync | input | 1 | Active-low horizontal sync in |
| vsync | input | 1 | Active-low vertical sync in |
| blank | input | 1 | Active-high blanking in |
| pix_out | output | 24 | Composited colour {R,G,B} |
| hsync_o | output | 1 | hsync delayed to match pix_out |
| vsync_o | output | 1 | vsync delayed to match pix_out |
| blank_o | output | 1 | blank delayed to match pix_out |

## Verification
A sprite edge and a rectangle edge can fall on the same pixel. Then one pixel is a pass-through and its neighbour is a blend, and the position decides which. The bench sets this up twice: the sprite's right and bottom edges abut the rectangle's left and top edges, and in a second case the two share a top-left corner. Each scanned pixel is compared against a behavioural model, so that an off-by-one at either edge shows as a wrong case choice. Sync transitions are also placed on those same pixels, to confirm that the delayed sync and the blended colour leave together in the next cycle.

// File: rtl/ac_pkg.sv
package ac_pkg;
  localparam int CH_W = 8;
  localparam int NUM_CH = 3;
  localparam int PIX_W = CH_W * NUM_CH;

  typedef logic [PIX_W-1:0] pix_t;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_SPR   = 2'd1,
    SRC_RECT  = 2'd2,
    SRC_BLEND = 2'd3
  } src_e;
endpackage

// File: rtl/ac_rect_hit.sv
module ac_rect_hit #(
  parameter int XW = 11,
  parameter int YW = 10,
  parameter int W  = 64,
  parameter int H  = 64
) (
  input  logic [XW-1:0] org_x,
  input  logic [YW-1:0] org_y,
  input  logic [XW-1:0] pos_x,
  input  logic [YW-1:0] pos_y,
  output logic          hit
);
  localparam int XE = XW + 1;
  localparam int YE = YW + 1;

  logic [XE-1:0] x_end;
  logic [YE-1:0] y_end;
  logic          in_x, in_y;

  always_comb begin
    x_end = {1'b0, org_x} + XE'(W);
    y_end = {1'b0, org_y} + YE'(H);
    in_x  = (pos_x >= org_x) && ({1'b0, pos_x} < x_end);
    in_y  = (pos_y >= org_y) && ({1'b0, pos_y} < y_end);
    hit   = in_x && in_y;
  end
endmodule

// File: rtl/ac_chan_mix.sv
module ac_chan_mix #(
  parameter int CW = 8,
  parameter int M  = 3,
  parameter int N  = 4
) (
  input  logic [CW-1:0] fg,
  input  logic [CW-1:0] bg,
  output logic [CW-1:0] mix
);
  localparam int SH = $clog2(N);
  localparam int PW = CW + SH + 1;
  localparam logic [PW-1:0] CMAX = PW'((1 << CW) - 1);

  logic [PW-1:0] acc;
  logic [PW-1:0] scaled;

  always_comb begin
    acc    = PW'(fg) * PW'(M) + PW'(bg) * PW'(N - M);
    scaled = acc >> SH;
    mix    = (scaled > CMAX) ? CMAX[CW-1:0] : scaled[CW-1:0];
  end
endmodule

// File: rtl/ac_sync_delay.sv
module ac_sync_delay #(
  parameter int DEPTH = 1,
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= RST_VAL;
          else     stage[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= RST_VAL;
          else     stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign dout = stage[DEPTH-1];
endmodule

// File: rtl/alpha_compositor.sv
module alpha_compositor #(
  parameter int HW        = 11,
  parameter int VW        = 10,
  parameter int SPR_W     = 64,
  parameter int SPR_H     = 64,
  parameter int RECT_SIZE = 128,
  parameter logic [23:0] RECT_COLOR = 24'hFF0000,
  parameter int ALPHA_M   = 3,
  parameter int ALPHA_N   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] hcount,
  input  logic [VW-1:0] vcount,
  input  logic [HW-1:0] sprite_x,
  input  logic [VW-1:0] sprite_y,
  input  logic [HW-1:0] rect_x,
  input  logic [VW-1:0] rect_y,
  input  logic [23:0]   sprite_rgb,
  input  logic          sprite_vld,
  input  logic          hsync,
  input  logic          vsync,
  input  logic          blank,
  output logic [23:0]   pix_out,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          blank_o
);
  import ac_pkg::*;

  localparam int LATENCY = 1;
  localparam int CW = CH_W;

  logic spr_in, spr_cov, rect_hit;
  pix_t blended, next_pix;
  src_e src;

  ac_rect_hit #(.XW(HW), .YW(VW), .W(SPR_W), .H(SPR_H)) u_spr_hit (
    .org_x(sprite_x), .org_y(sprite_y), .pos_x(hcount), .pos_y(vcount), .hit(spr_in)
  );

  ac_rect_hit #(.XW(HW), .YW(VW), .W(RECT_SIZE), .H(RECT_SIZE)) u_rect_hit (
    .org_x(rect_x), .org_y(rect_y), .pos_x(hcount), .pos_y(vcount), .hit(rect_hit)
  );

  assign spr_cov = spr_in && sprite_vld;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      ac_chan_mix #(.CW(CW), .M(ALPHA_M), .N(ALPHA_N)) u_mix (
        .fg (sprite_rgb[c*CW +: CW]),
        .bg (RECT_COLOR[c*CW +: CW]),
        .mix(blended[c*CW +: CW])
      );
    end
  endgenerate

  always_comb begin
    src = src_e'({rect_hit, spr_cov});
    unique case (src)
      SRC_SPR:   next_pix = sprite_rgb;
      SRC_RECT:  next_pix = RECT_COLOR;
      SRC_BLEND: next_pix = blended;
      default:   next_pix = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pix_out <= '0;
    else     pix_out <= next_pix;
  end

  ac_sync_delay #(.DEPTH(LATENCY), .WIDTH(3), .RST_VAL(3'b111)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({hsync, vsync, blank}),
    .dout({hsync_o, vsync_o, blank_o})
  );

  // R1: reset drives idle outputs on the following cycle
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (pix_out == '0 && hsync_o && vsync_o && blank_o));

  // R2: timing signals follow the inputs by one cycle
  p_sync_lag_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (hsync_o == $past(hsync) && vsync_o == $past(vsync)
                     && blank_o == $past(blank)));

  // R3: sprite-only pixels pass unchanged
  p_spr_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(spr_cov && !rect_hit)) |-> pix_out == $past(sprite_rgb));

  // R4: rectangle-only pixels carry the fixed colour
  p_rect_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!spr_cov && rect_hit)) |-> pix_out == RECT_COLOR);

  // R5: uncovered pixels are black
  p_empty_black_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!spr_cov && !rect_hit)) |-> pix_out == '0);

  // R6: blending two equal colours returns that colour
  p_equal_blend_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(spr_cov && rect_hit && sprite_rgb == RECT_COLOR))
      |-> pix_out == RECT_COLOR);
endmodule

// File: tb/sim_alpha_compositor.sv
module sim_alpha_compositor;
  localparam int AM = 3;
  localparam int AN = 4;
  localparam int SW = 64;
  localparam int RS = 128;
  localparam int WATCH = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] hcount = '0, sprite_x = '0, rect_x = '0;
  logic [9:0]  vcount = '0, sprite_y = '0, rect_y = '0;
  logic [23:0] sprite_rgb = '0;
  logic        sprite_vld = 1'b0;
  logic        hsync = 1'b0, vsync = 1'b0, blank = 1'b0;
  logic [23:0] pix_out;
  logic        hsync_o, vsync_o, blank_o;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;
  bit done = 0;

  logic [23:0] exp_pix;
  logic [2:0]  exp_sync;
  string       exp_tag;

  always #2 clk = ~clk;

  alpha_compositor u0 (
    .clk(clk), .rst(rst), .hcount(hcount), .vcount(vcount),
    .sprite_x(sprite_x), .sprite_y(sprite_y), .rect_x(rect_x), .rect_y(rect_y),
    .sprite_rgb(sprite_rgb), .sprite_vld(sprite_vld),
    .hsync(hsync), .vsync(vsync), .blank(blank),
    .pix_out(pix_out), .hsync_o(hsync_o), .vsync_o(vsync_o), .blank_o(blank_o)
  );

  function automatic int mixc(int s, int b);
    int v;
    v = (s * AM + b * (AN - AM)) / AN;
    if (v > 255) v = 255;
    return v;
  endfunction

  // Model: predicts the outputs that follow the next clock edge
  task automatic predict(input string extra);
    int h, v, sx, sy, bx, by;
    bit s_on, b_on;
    h = hcount; v = vcount; sx = sprite_x; sy = sprite_y; bx = rect_x; by = rect_y;
    if (rst) begin
      exp_pix = 24'h0; exp_sync = 3'b111; exp_tag = "R1";
      return;
    end
    s_on = sprite_vld && h >= sx && h < sx + SW && v >= sy && v < sy + SW;
    b_on = h >= bx && h < bx + RS && v >= by && v < by + RS;
    exp_sync = {hsync, vsync, blank};
    if (s_on && b_on) begin
      exp_pix = {8'(mixc(sprite_rgb[23:16], 255)), 8'(mixc(sprite_rgb[15:8], 0)),
                 8'(mixc(sprite_rgb[7:0], 0))};
      exp_tag = {"R6 ", extra};
    end else if (s_on) begin
      exp_pix = sprite_rgb; exp_tag = {"R3 ", extra};
    end else if (b_on) begin
      exp_pix = 24'hFF0000; exp_tag = {"R4 ", extra};
    end else begin
      exp_pix = 24'h0; exp_tag = {"R5 ", extra};
    end
  endtask

  task automatic compare();
    n_checks++;
    if (pix_out !== exp_pix) begin
      n_errors++;
      $display("FAIL %s pixel at t=%0t: got %h expected %h", exp_tag, $time, pix_out, exp_pix);
    end
    n_checks++;
    if ({hsync_o, vsync_o, blank_o} !== exp_sync) begin
      n_errors++;
      $display("FAIL R2 timing outputs at t=%0t: got %b expected %b", $time,
               {hsync_o, vsync_o, blank_o}, exp_sync);
    end
  endtask

  // Called at a falling edge with inputs already set
  task automatic cyc(input string extra);
    predict(extra);
    @(negedge clk);
    compare();
  endtask

  task automatic scan_line(input int v, input int hlo, input int hhi, input string extra);
    for (int h = hlo; h <= hhi; h++) begin
      hcount = 11'(h);
      vcount = 10'(v);
      if ((h % 11) == 3) sprite_rgb = 24'hFF0000;
      else sprite_rgb = {8'(h ^ v), 8'(h * 3 + 17), 8'(v * 5 + h)};
      sprite_vld = (h % 13) != 5;
      hsync = (h % 5) != 0;
      vsync = (v % 2) != 0;
      blank = (h % 7) < 3;
      cyc(extra);
    end
  endtask

  task automatic place(input int sx, input int sy, input int bx, input int by);
    sprite_x = 11'(sx); sprite_y = 10'(sy); rect_x = 11'(bx); rect_y = 10'(by);
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state with busy inputs
    rst = 1'b1; hsync = 0; vsync = 0; blank = 0;
    place(0, 0, 0, 0); hcount = 5; vcount = 5; sprite_vld = 1; sprite_rgb = 24'h123456;
    for (int i = 0; i < 3; i++) cyc("R1");
    rst = 1'b0;

    // Main function: overlapping layers, R3..R6 with R7/R8 edges
    place(100, 100, 140, 130);
    scan_line(99, 90, 280, "R7");
    scan_line(100, 90, 280, "R7");
    scan_line(129, 90, 280, "R8");
    scan_line(130, 90, 280, "R8");
    scan_line(163, 90, 280, "R7");
    scan_line(164, 90, 280, "R7");
    scan_line(200, 90, 280, "R8");
    scan_line(257, 90, 280, "R8");
    scan_line(258, 90, 280, "R8");

    // Sprite edges abut rectangle edges
    place(300, 200, 364, 264);
    scan_line(199, 290, 500, "R7");
    scan_line(263, 290, 500, "R7/R8");
    scan_line(264, 290, 500, "R7/R8");

    // Shared top-left corner
    place(50, 400, 50, 400);
    scan_line(400, 40, 190, "R7/R8");
    scan_line(463, 40, 190, "R7/R8");
    scan_line(464, 40, 190, "R8");
    scan_line(527, 40, 190, "R8");
    scan_line(528, 40, 190, "R8");

    // Reset in the middle of activity
    hcount = 60; vcount = 410; sprite_vld = 1; hsync = 0; vsync = 0; blank = 0;
    rst = 1'b1;
    for (int i = 0; i < 3; i++) cyc("R1");
    rst = 1'b0;
    scan_line(410, 40, 70, "R1");

    done = 1;
  end

  initial begin
    while (!done && cycles < WATCH) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule